// File: doc/BRIEF.md
# Multi-Agent GPIO Output Priority Mapper

This block merges the pin writes of four small sequencer agents into one
registered output-level vector and one registered output-direction vector
for a 30-pin GPIO bank. Every agent can issue two writes in a cycle. The
first is a data write, which uses either the agent's wide window or its
narrow window. The second is a side-set write, which uses the agent's
side window. Each window is a contiguous run of pins, given by a base pin
and a pin count. The run wraps past the top pin back to pin 0. Windows may
overlap, within one agent and across agents.

For every pin, all candidate writes are resolved combinationally, and
level and direction are resolved separately. The higher-numbered agent
always wins. Within one agent, the side-set write beats the data write.
A pin that no write touches keeps its value. The resolved vectors are
loaded on the next rising clock edge.

Top module: `gpio_prio_mapper`

## Requirements
- R1: While `rst_n` is low at a rising edge, both `pin_level` and `pin_dir` become all zeros on that edge, whatever the write inputs are.
- R2: Bit i of a write's data lands on pin (base + i) mod 30. A base value of 30 or 31 therefore acts as base 0 or 1.
- R3: The number of pins a write touches is its count clamped to at most 30 for the wide window, and to at most 5 for the narrow window and the side window. A count of zero touches no pin.
- R4: A data write uses the wide window (`out_base`, `out_cnt`) when `dw_use_set` is 0. It uses the narrow window (`set_base`, `set_cnt`) when `dw_use_set` is 1. In both cases it takes its bits from `dw_data` starting at bit 0.
- R5: When writes from different agents touch the same pin, with the same target (level or direction), the write from the highest-numbered agent takes effect.
- R6: When one agent's data write and side-set write touch the same pin, with the same target, the side-set value takes effect. A higher-numbered agent's data write still beats a lower-numbered agent's side-set write.
- R7: A pin whose level (or direction) is touched by no valid write keeps its previous level (or direction).
- R8: A write with its to-direction flag set to 1 changes only `pin_dir`. A write with that flag set to 0 changes only `pin_level`. A level write and a direction write to the same pin in one cycle both take effect.
- R9: A write whose valid strobe is 0 has no effect on either output.
- R10: The result of the writes presented before a rising edge appears on `pin_level` and `pin_dir` right after that edge: one cycle of latency, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| out_base | input | 4x5 | Per-agent base pin of the wide data window |
| out_cnt | input | 4x6 | Per-agent pin count of the wide data window |
| set_base | input | 4x5 | Per-agent base pin of the narrow data window |
| set_cnt | input | 4x6 | Per-agent pin count of the narrow data window |
| side_base | input | 4x5 | Per-agent base pin of the side-set window |
| side_cnt | input | 4x6 | Per-agent pin count of the side-set window |
| dw_valid | input | 4 | Per-agent data write strobe |
| dw_use_set | input | 4 | Per-agent data window select (0 wide, 1 narrow) |
| dw_to_dir | input | 4 | Per-agent data write target (0 level, 1 direction) |
| dw_data | input | 4x32 | Per-agent data write bits |
| sw_valid | input | 4 | Per-agent side-set write strobe |
| sw_to_dir | input | 4 | Per-agent side-set target (0 level, 1 direction) |
| sw_data | input | 4x5 | Per-agent side-set bits |
| pin_level | output | 30 | Registered output level per pin |
| pin_dir | output | 30 | Registered output direction per pin (1 drives) |

## Verification
The hardest case to reach from the ports is a pin hit by several writes in
one cycle that disagree: a wrapped window of a low agent, a side-set of the
same agent, and a data write of a higher agent, all on the same pin.
Random stimulus with 5-bit bases and counts up to 39 produces such stacks
often, including clamped and wrapping windows. Directed cycles then build
each precedence pair on purpose. These cover the wrap at pin 29, clamping
and zero counts, and a level write paired with a direction write on the
same pins.

// File: rtl/gpm_pkg.sv
// Shared helpers for the GPIO priority mapper.
// Assumes: only elaboration-time and combinational use.
package gpm_pkg;

    // Smaller of two integers, used for count clamping.
    function automatic int min_int(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/gpm_lane.sv
// gpm_lane: spreads one write request over the pin space.
// Bit i of data lands on pin (base + i) mod NUM_PINS, for i below the
// effective count. The effective count is cnt clamped to DATA_W and to
// NUM_PINS. An invalid request touches no pin.
// Assumes: base may exceed NUM_PINS-1 and is reduced modulo NUM_PINS.
module gpm_lane #(
    parameter int NUM_PINS = 30,
    parameter int DATA_W   = 32,
    parameter int BASE_W   = 5,
    parameter int CNT_W    = 6
) (
    input  logic                vld,
    input  logic [BASE_W-1:0]   base,
    input  logic [CNT_W-1:0]    cnt,
    input  logic [DATA_W-1:0]   data,
    output logic [NUM_PINS-1:0] hit,
    output logic [NUM_PINS-1:0] val
);
    localparam int LIM   = gpm_pkg::min_int(DATA_W, NUM_PINS);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    // Map every pin back to its bit offset and mark the pins in range.
    always_comb begin
        int eff;
        int b;
        int off;
        eff = vld ? gpm_pkg::min_int(int'(cnt), LIM) : 0;
        b   = int'(base) % NUM_PINS;
        hit = '0;
        val = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            off = (p + NUM_PINS - b) % NUM_PINS;
            if (off < eff) begin
                hit[p] = 1'b1;
                val[p] = data[off[IDX_W-1:0]];
            end
        end
        // R3
        lane_count_chk: assert ($countones(hit) == eff);
        // R9
        lane_idle_chk: assert (vld || (hit == '0));
    end
endmodule

// File: rtl/gpm_resolve.sv
// gpm_resolve: merges the per-agent pin writes into next-state vectors.
// Writes are applied in ascending priority: agent 0 data, agent 0 side,
// agent 1 data, and so on. The last writer of a pin wins. Level and
// direction are merged separately. Pins that nobody writes keep the
// current value.
// Assumes: hit/val pairs come from gpm_lane instances.
module gpm_resolve #(
    parameter int NUM_AGENTS = 4,
    parameter int NUM_PINS   = 30
) (
    input  logic [NUM_PINS-1:0]                  cur_lvl,
    input  logic [NUM_PINS-1:0]                  cur_dir,
    input  logic [NUM_AGENTS-1:0][NUM_PINS-1:0]  d_hit,
    input  logic [NUM_AGENTS-1:0][NUM_PINS-1:0]  d_val,
    input  logic [NUM_AGENTS-1:0]                d_to_dir,
    input  logic [NUM_AGENTS-1:0][NUM_PINS-1:0]  s_hit,
    input  logic [NUM_AGENTS-1:0][NUM_PINS-1:0]  s_val,
    input  logic [NUM_AGENTS-1:0]                s_to_dir,
    output logic [NUM_PINS-1:0]                  nxt_lvl,
    output logic [NUM_PINS-1:0]                  nxt_dir,
    output logic [NUM_PINS-1:0]                  lvl_touch,
    output logic [NUM_PINS-1:0]                  dir_touch
);
    // Overlay the writes lowest priority first, so the last one stands.
    always_comb begin
        nxt_lvl   = cur_lvl;
        nxt_dir   = cur_dir;
        lvl_touch = '0;
        dir_touch = '0;
        for (int a = 0; a < NUM_AGENTS; a++) begin
            if (d_to_dir[a]) begin
                nxt_dir   = (nxt_dir & ~d_hit[a]) | (d_val[a] & d_hit[a]);
                dir_touch = dir_touch | d_hit[a];
            end else begin
                nxt_lvl   = (nxt_lvl & ~d_hit[a]) | (d_val[a] & d_hit[a]);
                lvl_touch = lvl_touch | d_hit[a];
            end
            if (s_to_dir[a]) begin
                nxt_dir   = (nxt_dir & ~s_hit[a]) | (s_val[a] & s_hit[a]);
                dir_touch = dir_touch | s_hit[a];
            end else begin
                nxt_lvl   = (nxt_lvl & ~s_hit[a]) | (s_val[a] & s_hit[a]);
                lvl_touch = lvl_touch | s_hit[a];
            end
        end
    end
endmodule

// File: rtl/gpio_prio_mapper.sv
// gpio_prio_mapper: top of the multi-agent GPIO output mapper.
// Every agent has a data write (wide or narrow window) and a side-set
// write. The data window select picks the base and count; the narrow
// window count is clamped to SET_W. Lanes spread the writes over the
// pins, the resolver applies priority, and two registers hold the result.
// Assumes: synchronous active-low reset; all inputs synchronous to clk.
module gpio_prio_mapper #(
    parameter int NUM_AGENTS = 4,
    parameter int NUM_PINS   = 30,
    parameter int DATA_W     = 32,
    parameter int SET_W      = 5,
    parameter int SIDE_W     = 5,
    parameter int BASE_W     = $clog2(NUM_PINS),
    parameter int CNT_W      = $clog2(DATA_W + 1)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_AGENTS-1:0][BASE_W-1:0]    out_base,
    input  logic [NUM_AGENTS-1:0][CNT_W-1:0]     out_cnt,
    input  logic [NUM_AGENTS-1:0][BASE_W-1:0]    set_base,
    input  logic [NUM_AGENTS-1:0][CNT_W-1:0]     set_cnt,
    input  logic [NUM_AGENTS-1:0][BASE_W-1:0]    side_base,
    input  logic [NUM_AGENTS-1:0][CNT_W-1:0]     side_cnt,
    input  logic [NUM_AGENTS-1:0]                dw_valid,
    input  logic [NUM_AGENTS-1:0]                dw_use_set,
    input  logic [NUM_AGENTS-1:0]                dw_to_dir,
    input  logic [NUM_AGENTS-1:0][DATA_W-1:0]    dw_data,
    input  logic [NUM_AGENTS-1:0]                sw_valid,
    input  logic [NUM_AGENTS-1:0]                sw_to_dir,
    input  logic [NUM_AGENTS-1:0][SIDE_W-1:0]    sw_data,
    output logic [NUM_PINS-1:0]                  pin_level,
    output logic [NUM_PINS-1:0]                  pin_dir
);
    localparam int TOP = NUM_AGENTS - 1;

    logic [NUM_AGENTS-1:0][NUM_PINS-1:0] d_hit, d_val, s_hit, s_val;
    logic [NUM_AGENTS-1:0][BASE_W-1:0]   d_base;
    logic [NUM_AGENTS-1:0][CNT_W-1:0]    d_cnt;
    logic [NUM_PINS-1:0] nxt_lvl, nxt_dir, lvl_touch, dir_touch;

    for (genvar a = 0; a < NUM_AGENTS; a++) begin : g_agent
        // Choose the data window and clamp the narrow window count.
        always_comb begin
            d_base[a] = dw_use_set[a] ? set_base[a] : out_base[a];
            if (!dw_use_set[a])
                d_cnt[a] = out_cnt[a];
            else if (int'(set_cnt[a]) > SET_W)
                d_cnt[a] = CNT_W'(SET_W);
            else
                d_cnt[a] = set_cnt[a];
        end

        gpm_lane #(
            .NUM_PINS(NUM_PINS), .DATA_W(DATA_W),
            .BASE_W(BASE_W), .CNT_W(CNT_W)
        ) data_lane_i (
            .vld(dw_valid[a]), .base(d_base[a]), .cnt(d_cnt[a]),
            .data(dw_data[a]), .hit(d_hit[a]), .val(d_val[a])
        );

        gpm_lane #(
            .NUM_PINS(NUM_PINS), .DATA_W(SIDE_W),
            .BASE_W(BASE_W), .CNT_W(CNT_W)
        ) side_lane_i (
            .vld(sw_valid[a]), .base(side_base[a]), .cnt(side_cnt[a]),
            .data(sw_data[a]), .hit(s_hit[a]), .val(s_val[a])
        );
    end

    gpm_resolve #(
        .NUM_AGENTS(NUM_AGENTS), .NUM_PINS(NUM_PINS)
    ) resolve_i (
        .cur_lvl(pin_level), .cur_dir(pin_dir),
        .d_hit(d_hit), .d_val(d_val), .d_to_dir(dw_to_dir),
        .s_hit(s_hit), .s_val(s_val), .s_to_dir(sw_to_dir),
        .nxt_lvl(nxt_lvl), .nxt_dir(nxt_dir),
        .lvl_touch(lvl_touch), .dir_touch(dir_touch)
    );

    // Load the resolved level and direction, or clear them in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_level <= '0;
            pin_dir   <= '0;
        end else begin
            pin_level <= nxt_lvl;
            pin_dir   <= nxt_dir;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pin_level == '0 && pin_dir == '0));

    // R7
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pin_level ^ $past(pin_level)) & ~$past(lvl_touch)) == '0));

    // R7 R8
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pin_dir ^ $past(pin_dir)) & ~$past(dir_touch)) == '0));

    // R5 R6
    top_side_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pin_level ^ $past(s_val[TOP]))
                   & $past(s_hit[TOP] & {NUM_PINS{~sw_to_dir[TOP]}})) == '0));

    // R5
    top_data_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pin_dir ^ $past(d_val[TOP]))
                   & $past(d_hit[TOP] & {NUM_PINS{dw_to_dir[TOP]}}
                           & ~(s_hit[TOP] & {NUM_PINS{sw_to_dir[TOP]}}))) == '0));
endmodule

// File: tb/gpio_prio_mapper_tb_top.sv
`timescale 1ns/1ps
module gpio_prio_mapper_tb_top;
    localparam int NA = 4;
    localparam int NP = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NA-1:0][4:0]  out_base, set_base, side_base;
    logic [NA-1:0][5:0]  out_cnt, set_cnt, side_cnt;
    logic [NA-1:0]       dw_valid, dw_use_set, dw_to_dir, sw_valid, sw_to_dir;
    logic [NA-1:0][31:0] dw_data;
    logic [NA-1:0][4:0]  sw_data;
    logic [NP-1:0]       pin_level, pin_dir;
    logic [NP-1:0]       exp_lvl, exp_dir;
    int compared = 0;
    int mismatched = 0;

    gpio_prio_mapper dut_i (
        .clk(clk), .rst_n(rst_n),
        .out_base(out_base), .out_cnt(out_cnt),
        .set_base(set_base), .set_cnt(set_cnt),
        .side_base(side_base), .side_cnt(side_cnt),
        .dw_valid(dw_valid), .dw_use_set(dw_use_set), .dw_to_dir(dw_to_dir),
        .dw_data(dw_data), .sw_valid(sw_valid), .sw_to_dir(sw_to_dir),
        .sw_data(sw_data), .pin_level(pin_level), .pin_dir(pin_dir)
    );

    always #10 clk = ~clk;

    // Bench reference: walk each write bit by bit in priority order.
    function automatic void advance();
        logic [NP-1:0] nl;
        logic [NP-1:0] nd;
        int b;
        int c;
        int p;
        nl = exp_lvl;
        nd = exp_dir;
        for (int a = 0; a < NA; a++) begin
            if (dw_valid[a]) begin
                b = dw_use_set[a] ? int'(set_base[a]) : int'(out_base[a]);
                c = dw_use_set[a] ? ((set_cnt[a] > 5) ? 5 : int'(set_cnt[a]))
                                  : ((out_cnt[a] > 30) ? 30 : int'(out_cnt[a]));
                for (int i = 0; i < c; i++) begin
                    p = (b + i) % NP;
                    if (dw_to_dir[a]) nd[p] = dw_data[a][i];
                    else              nl[p] = dw_data[a][i];
                end
            end
            if (sw_valid[a]) begin
                b = int'(side_base[a]);
                c = (side_cnt[a] > 5) ? 5 : int'(side_cnt[a]);
                for (int i = 0; i < c; i++) begin
                    p = (b + i) % NP;
                    if (sw_to_dir[a]) nd[p] = sw_data[a][i];
                    else              nl[p] = sw_data[a][i];
                end
            end
        end
        exp_lvl = nl;
        exp_dir = nd;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [NP-1:0] act, input logic [NP-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic clear_all();
        out_base = '0; out_cnt = '0; set_base = '0; set_cnt = '0;
        side_base = '0; side_cnt = '0;
        dw_valid = '0; dw_use_set = '0; dw_to_dir = '0; dw_data = '0;
        sw_valid = '0; sw_to_dir = '0; sw_data = '0;
    endtask

    task automatic randomize_inputs();
        for (int a = 0; a < NA; a++) begin
            out_base[a]  = 5'($urandom % 32);  out_cnt[a]  = 6'($urandom % 40);
            set_base[a]  = 5'($urandom % 32);  set_cnt[a]  = 6'($urandom % 9);
            side_base[a] = 5'($urandom % 32);  side_cnt[a] = 6'($urandom % 9);
            dw_valid[a]  = 1'($urandom % 2);   dw_use_set[a] = 1'($urandom % 2);
            dw_to_dir[a] = 1'($urandom % 2);   dw_data[a] = $urandom;
            sw_valid[a]  = 1'($urandom % 2);   sw_to_dir[a] = 1'($urandom % 2);
            sw_data[a]   = 5'($urandom % 32);
        end
    endtask

    // Apply current inputs across one edge and compare (R10 latency).
    task automatic step(input string tag);
        advance();
        @(posedge clk);
        @(negedge clk);
        check(tag, "level", pin_level, exp_lvl);
        check(tag, "dir", pin_dir, exp_dir);
    endtask

    // Hold reset across one edge with random writes pending.
    task automatic reset_step();
        rst_n = 1'b0;
        randomize_inputs();
        @(posedge clk);
        @(negedge clk);
        exp_lvl = '0;
        exp_dir = '0;
        check("R1", "level", pin_level, '0);
        check("R1", "dir", pin_dir, '0);
        rst_n = 1'b1;
        clear_all();
    endtask

    initial begin
        #(20 * 150000);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5EED));
        clear_all();
        @(negedge clk);
        reset_step();
        reset_step();

        // R2: wrap past pin 29.
        clear_all(); dw_valid[0] = 1; out_base[0] = 28; out_cnt[0] = 4;
        dw_data[0] = 32'hB; step("R2");
        // R2: base 31 acts as base 1.
        clear_all(); dw_valid[0] = 1; out_base[0] = 31; out_cnt[0] = 2;
        dw_data[0] = 32'h2; step("R2");
        // R3: narrow count 7 clamps to 5.
        clear_all(); dw_valid[1] = 1; dw_use_set[1] = 1; set_base[1] = 10;
        set_cnt[1] = 7; dw_data[1] = '1; step("R3");
        // R3: zero count touches nothing.
        clear_all(); dw_valid[2] = 1; out_base[2] = 0; out_cnt[2] = 0;
        dw_data[2] = 32'h0; step("R3");
        // R3: wide count 40 clamps to the whole bank.
        clear_all(); dw_valid[2] = 1; out_base[2] = 7; out_cnt[2] = 40;
        dw_data[2] = 32'h0; step("R3");
        // R3: side count 9 clamps to 5.
        clear_all(); sw_valid[0] = 1; side_base[0] = 20; side_cnt[0] = 9;
        sw_data[0] = 5'h1F; step("R3");
        // R4: window select picks narrow window base.
        clear_all(); dw_valid[3] = 1; dw_use_set[3] = 1; out_base[3] = 0;
        out_cnt[3] = 3; set_base[3] = 15; set_cnt[3] = 3; dw_data[3] = 32'h5;
        step("R4");
        // R5: agent 3 beats agent 0 on shared pins.
        clear_all(); dw_valid[0] = 1; out_base[0] = 2; out_cnt[0] = 8;
        dw_data[0] = 32'hFF; dw_valid[3] = 1; out_base[3] = 4; out_cnt[3] = 4;
        dw_data[3] = 32'h0; step("R5");
        // R6: side-set beats data within agent 1.
        clear_all(); dw_valid[1] = 1; out_base[1] = 24; out_cnt[1] = 6;
        dw_data[1] = 32'h0; sw_valid[1] = 1; side_base[1] = 25; side_cnt[1] = 3;
        sw_data[1] = 5'h7; step("R6");
        // R6: agent 2 data beats agent 1 side-set.
        clear_all(); sw_valid[1] = 1; side_base[1] = 25; side_cnt[1] = 3;
        sw_data[1] = 5'h0; dw_valid[2] = 1; out_base[2] = 26; out_cnt[2] = 1;
        dw_data[2] = 32'h1; step("R6");
        // R8: level and direction on the same pins both apply.
        clear_all(); dw_valid[0] = 1; out_base[0] = 12; out_cnt[0] = 4;
        dw_data[0] = 32'hA; sw_valid[0] = 1; sw_to_dir[0] = 1; side_base[0] = 12;
        side_cnt[0] = 4; sw_data[0] = 5'hF; step("R8");
        // R9: invalid writes leave both outputs alone.
        clear_all(); out_base[1] = 0; out_cnt[1] = 30; dw_data[1] = '1;
        side_base[2] = 12; side_cnt[2] = 5; sw_data[2] = 5'h0; step("R9");
        // R7: nothing valid, everything holds.
        clear_all(); step("R7");

        // R5 R6 R7 R8 R10: random mixes.
        for (int n = 0; n < 2000; n++) begin
            randomize_inputs();
            step("R5 R6 R7 R8 R10 random");
            if (n == 1000) reset_step();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule